// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single management transactions on a two-wire MDIO bus on behalf of software. A transaction is described by one pre-packed 32-bit word written into the frame register. That write starts the transaction. The block first sends a preamble of 32 ones. It then shifts the packed word out on the data line, most significant bit first, and toggles the management clock MDC at a rate set by a divider register.

For a read transaction the block stops driving the data line for the second half of the turnaround and for the whole data phase. It samples the sixteen bits that the PHY returns on MDC rising edges. At the end of the frame it stores those bits into the low half of the frame register. Every finished transaction sets a sticky completion flag in an event register, and software clears that flag by writing a one to it. Software polls the flag, then reads the frame register to get the result.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: When no transaction is in progress and the divider field is nonzero, a frame write starts a transaction. MDIO carries 32 ones, then the 32 frame bits from bit 31 down to bit 0, one bit per MDC cycle. The frame layout is start 31:30 = 01, opcode 29:28, PHY address 27:23, register address 22:18, turnaround 17:16 = 10, data 15:0.
- R2: With divider field N (divider register bits DIV_W:1), each MDC period lasts 2*(N+1) clock cycles. MDC is low whenever no transaction is in progress.
- R3: MDIO output changes only on a falling edge of MDC. Read data is sampled on MDC rising edges.
- R4: Opcode 10 (bits 29:28) marks a read. During a read, the output enable is low from frame bit 16 through frame bit 0. Any other opcode keeps the output enable high for all 64 bits. The output enable is low when idle.
- R5: At the end of a read, the 16 sampled bits (first one received lands in bit 15) replace frame bits 15:0, and bits 31:16 are kept. A non-read transaction leaves the frame register unchanged.
- R6: The end of a transaction sets bit 23 of the event register. A write to the event register with bit 23 = 1 clears it. All other event bits read 0.
- R7: If the divider field is zero, a frame write still stores the word, but no transaction starts, MDC stays low and the event bit stays clear.
- R8: Writes to the frame register or to the divider register are ignored while a transaction is in progress.
- R9: After reset the frame, divider and event registers read zero, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_wr | input | 1 | Write strobe for the frame register |
| frame_wdata | input | 32 | Packed frame word |
| div_wr | input | 1 | Write strobe for the divider register |
| div_wdata | input | 32 | Divider register value; field in bits DIV_W:1 |
| evt_wr | input | 1 | Write strobe for the event register |
| evt_wdata | input | 32 | Event write data; a one in bit 23 clears the flag |
| mdio_i | input | 1 | MDIO level as seen on the pin |
| frame_rd | output | 32 | Frame register contents |
| event_rd | output | 32 | Event register contents |
| div_rd | output | 32 | Divider register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench sweeps all 32 PHY addresses with both read and write opcodes at several divider values. It recomputes the bit stream, the output-enable mask and the MDC period from the frame word and the divider value. An off-by-one bus release would show up as a wrong output-enable mask at frame bit 16 or 17, and a sampling slip would return read data shifted by one bit. A divider that ignores the +1 term or the factor of two would give MDC periods of the wrong length. Separate cases cover three situations: a zero divider, where a careless design would toggle MDC or raise a false completion; register writes during a busy frame, which would corrupt the frame in flight; and clearing the event flag.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32,
  parameter int EVT_BIT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_wr,
  input  logic [31:0] frame_wdata,
  input  logic        div_wr,
  input  logic [31:0] div_wdata,
  input  logic        evt_wr,
  input  logic [31:0] evt_wdata,
  input  logic        mdio_i,
  output logic [31:0] frame_rd,
  output logic [31:0] event_rd,
  output logic [31:0] div_rd,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int TOTAL = PRE_LEN + 32;
  localparam int BW    = $clog2(TOTAL);

  logic [31:0]      frame_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic [BW-1:0]    bitcnt;
  logic [15:0]      rx;
  logic             evt_q, busy, mdc_q;

  logic          tick, rise, fall, last, is_read, in_pre, launch;
  logic [BW-1:0] fpos;

  assign tick    = busy && (cnt == div_q);
  assign rise    = tick && !mdc_q;
  assign fall    = tick && mdc_q;
  assign last    = bitcnt == BW'(TOTAL - 1);
  assign is_read = frame_q[29:28] == 2'b10;
  assign in_pre  = bitcnt < BW'(PRE_LEN);
  assign fpos    = BW'(TOTAL - 1) - bitcnt;
  assign launch  = frame_wr && !busy && (div_q != '0);

  assign mdio_o   = !busy || in_pre || frame_q[fpos[4:0]];
  assign mdio_oe  = busy && !(is_read && !in_pre && fpos <= BW'(16));
  assign mdc      = mdc_q;
  assign frame_rd = frame_q;
  assign event_rd = 32'(evt_q) << EVT_BIT;
  assign div_rd   = 32'(div_q) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      div_q   <= '0;
      cnt     <= '0;
      bitcnt  <= '0;
      rx      <= '0;
      evt_q   <= 1'b0;
      busy    <= 1'b0;
      mdc_q   <= 1'b0;
    end else begin
      if (frame_wr && !busy) frame_q <= frame_wdata;
      if (div_wr && !busy)   div_q   <= div_wdata[DIV_W:1];
      if (launch) begin
        busy   <= 1'b1;
        cnt    <= '0;
        bitcnt <= '0;
        mdc_q  <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (rise) begin
          mdc_q <= 1'b1;
          if (!in_pre && fpos <= BW'(15)) rx <= {rx[14:0], mdio_i};
        end
        if (fall) begin
          mdc_q <= 1'b0;
          if (last) begin
            busy <= 1'b0;
            if (is_read) frame_q[15:0] <= rx;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
      if (evt_wr && evt_wdata[EVT_BIT]) evt_q <= 1'b0;
      if (fall && last) evt_q <= 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R4
  AST_DIV_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_rd == 32'd0) |-> (!busy && !mdc)); // R7
  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R3
  AST_DONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> event_rd[EVT_BIT]); // R6
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(frame_rd) && $stable(div_rd))); // R8
endmodule

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic frame_wr = 0, div_wr = 0, evt_wr = 0, mdio_i = 0;
  logic [31:0] frame_wdata = 0, div_wdata = 0, evt_wdata = 0;
  logic [31:0] frame_rd, event_rd, div_rd;
  logic mdc, mdio_o, mdio_oe;

  int n_chk = 0, n_bad = 0;
  int rcnt = 0, per_err = 0, r3_err = 0, exp_per = 4;
  time last_rise = 0;
  logic [63:0] txbits, oebits;
  logic [15:0] phy_data = 0;
  logic prev_o = 1, prev_mdc = 0;

  mdio_frame_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge mdc) begin
    if (rcnt < 64) begin
      txbits[63-rcnt] = mdio_o;
      oebits[63-rcnt] = mdio_oe;
    end
    if (rcnt > 0 && ($time - last_rise) != exp_per * CLK_PERIOD) per_err++;
    last_rise = $time;
    rcnt++;
  end

  always @(negedge mdc)
    if (rcnt >= 48 && rcnt < 64) mdio_i = phy_data[63-rcnt];

  always @(negedge clk) begin
    if (rst_n && mdio_o !== prev_o && !(prev_mdc && !mdc)) r3_err++;
    prev_o = mdio_o;
    prev_mdc = mdc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_div(input int n);
    @(negedge clk); div_wr = 1; div_wdata = 32'(n) << 1;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic clr_evt();
    @(negedge clk); evt_wr = 1; evt_wdata = 32'h0080_0000;
    @(negedge clk); evt_wr = 0;
  endtask

  task automatic wait_evt(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (event_rd[23]) begin ok = 1; break; end
    end
  endtask

  task automatic run_frame(input logic [31:0] fr, input logic [15:0] pd, input int n);
    bit ok, rd;
    logic [31:0] exp_fr;
    rd = fr[29:28] == 2'b10;
    phy_data = pd; exp_per = 2 * (n + 1); rcnt = 0; per_err = 0; r3_err = 0;
    @(negedge clk); frame_wr = 1; frame_wdata = fr;
    @(negedge clk); frame_wr = 0;
    wait_evt(ok);
    chk(ok, "R6 completion flag", 64'(event_rd), 64'h0080_0000);
    chk(rcnt == 64, "R1 mdc cycle count", 64'(rcnt), 64'd64);
    chk(per_err == 0, "R2 mdc period", 64'(per_err), 64'd0);
    chk(r3_err == 0, "R3 output change off falling edge", 64'(r3_err), 64'd0);
    if (rd) begin
      chk(txbits[63:17] == {32'hFFFF_FFFF, fr[31:17]}, "R1 read header bits", txbits, {32'hFFFF_FFFF, fr});
      chk(oebits == 64'hFFFF_FFFF_FFFE_0000, "R4 read release mask", oebits, 64'hFFFF_FFFF_FFFE_0000);
      exp_fr = {fr[31:16], pd};
    end else begin
      chk(txbits == {32'hFFFF_FFFF, fr}, "R1 write bit stream", txbits, {32'hFFFF_FFFF, fr});
      chk(oebits == '1, "R4 write drive mask", oebits, '1);
      exp_fr = fr;
    end
    chk(frame_rd == exp_fr, "R5 frame after transaction", 64'(frame_rd), 64'(exp_fr));
    chk(!mdc && !mdio_oe, "R2 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
    clr_evt();
    chk(event_rd == 0, "R6 flag cleared", 64'(event_rd), 64'd0);
  endtask

  function automatic logic [31:0] mk(input bit rd, input int phy, input int rg, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, 5'(phy), 5'(rg), 2'b10, d};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(frame_rd == 0 && event_rd == 0 && div_rd == 0, "R9 registers after reset",
        {frame_rd, event_rd}, 64'd0);
    chk(!mdc && !mdio_oe, "R9 pins after reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R7 divider zero blocks the transaction
    rcnt = 0;
    @(negedge clk); frame_wr = 1; frame_wdata = mk(1, 3, 4, 16'h1234);
    @(negedge clk); frame_wr = 0;
    repeat (300) @(negedge clk);
    chk(rcnt == 0 && !mdc, "R7 no mdc with zero divider", 64'(rcnt), 64'd0);
    chk(event_rd == 0, "R7 no completion with zero divider", 64'(event_rd), 64'd0);
    chk(frame_rd == mk(1, 3, 4, 16'h1234), "R7 frame stored", 64'(frame_rd), 64'(mk(1, 3, 4, 16'h1234)));

    // sweep all PHY addresses, alternating opcodes
    set_div(1);
    chk(div_rd == 32'd2, "R2 divider readback", 64'(div_rd), 64'd2);
    for (int p = 0; p < 32; p++)
      run_frame(mk(p[0], p, p ^ 5, 16'(p * 16'h0913) ^ 16'h5A3C), 16'hA5C3 ^ 16'(p * 16'h1357), 1);
    for (int n = 2; n <= 4; n++) begin
      set_div(n);
      run_frame(mk(1, 31 - n, n, 16'h0000), 16'(16'hBEEF + n), n);
      run_frame(mk(0, n, 31, 16'hFFFF - 16'(n)), 16'h0, n);
    end

    // R8 writes while busy are ignored
    set_div(3);
    phy_data = 16'h0;
    @(negedge clk); frame_wr = 1; frame_wdata = mk(0, 9, 10, 16'hC0DE);
    @(negedge clk); frame_wr = 0;
    repeat (40) @(negedge clk);
    frame_wr = 1; frame_wdata = 32'h1111_1111; div_wr = 1; div_wdata = 32'h0000_0010;
    @(negedge clk); frame_wr = 0; div_wr = 0;
    begin
      bit ok;
      wait_evt(ok);
      chk(ok, "R8 first frame completes", 64'(event_rd), 64'h0080_0000);
    end
    chk(frame_rd == mk(0, 9, 10, 16'hC0DE), "R8 frame write ignored while busy",
        64'(frame_rd), 64'(mk(0, 9, 10, 16'hC0DE)));
    chk(div_rd == 32'd6, "R8 divider write ignored while busy", 64'(div_rd), 64'd6);
    clr_evt();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule